// File: doc/BRIEF.md
# Digital IQ Phase Regulation Loop

The block closes a phase and amplitude loop around an RF drive chain. It runs on a single 50 MHz sample clock. Each clock it receives one signed ADC sample of an intermediate-frequency signal whose carrier lies at exactly one quarter of the sample rate, so every carrier cycle covers four samples. From each group of four samples it recovers an in-phase/quadrature pair by adding and subtracting samples, with no multipliers and no NCO. It then subtracts that pair from a programmable I/Q setpoint to form a per-component error.

When the loop is enabled, each component receives a proportional-plus-integral correction with programmable unsigned gains. The corrected pair is re-modulated into a four-sample IF pattern that drives a DAC at the same rate. When the loop is disabled, the integrators are held at zero and the setpoint is sent straight to the modulator. All arithmetic saturates to the 14-bit sample range. The block produces one new measurement and one new correction per carrier cycle (80 ns). A change at the ADC reaches the DAC well inside 30 clocks.

Top module: `iq_phase_loop`

## Requirements
- R1: While `rst_n` is low, `dac_o`, `meas_i`, `meas_q`, `err_i`, `err_q` and `meas_valid` are all zero.
- R2: The first sample after reset and every fourth sample after it is carrier slot 0. The slots carry +I, +Q, −I, −Q. At the edge that captures slot 3, `meas_i` becomes floor((slot0 − slot2)/2) and `meas_q` becomes floor((slot1 − slot3)/2).
- R3: `meas_valid` is high for exactly the one cycle that follows each measurement update and is low otherwise. `meas_i` and `meas_q` stay unchanged while it is low.
- R4: At the edge after a measurement update (slot 0), `err_i`/`err_q` become setpoint minus measurement, saturated to [−8192, 8191].
- R5: While `loop_en` is low, the correction equals the setpoint, reloaded at every edge, and both integrators are zero.
- R6: At the edge of slot 0, 1, 2 and 3 the DAC register loads I, Q, −I and −Q of the current correction. A negated −8192 saturates to 8191.
- R7: With the loop enabled, at each slot-1 edge the correction becomes sat(setpoint + floor(kp·err/16) + integrator). The gains are 8-bit unsigned values, so 16 means unity.
- R8: With the loop enabled, at each slot-1 edge every integrator adds floor(ki·err/16) and saturates at 8191 or −8192 rather than wrapping.
- R9: Lowering `loop_en` clears both integrators, so that a later enable starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_i | input | 14 | Signed IF sample from the ADC |
| loop_en | input | 1 | 1 = closed loop, 0 = setpoint passes through |
| sp_i | input | 14 | Signed in-phase setpoint |
| sp_q | input | 14 | Signed quadrature setpoint |
| kp | input | 8 | Unsigned proportional gain, 16 = unity |
| ki | input | 8 | Unsigned integral gain, 16 = unity |
| dac_o | output | 14 | Signed IF sample to the DAC |
| meas_i | output | 14 | Measured in-phase component |
| meas_q | output | 14 | Measured quadrature component |
| err_i | output | 14 | Saturated in-phase error |
| err_q | output | 14 | Saturated quadrature error |
| meas_valid | output | 1 | One-cycle pulse after each measurement update |

## Verification
The measurement is due at the slot-3 edge and the error one edge later, so every measurement vector is held for eight clocks starting at a slot-0 boundary. After those eight clocks, both the measurement and the error reflect only the new samples. The correction updates at the slot-1 edge and reaches the DAC from the next slot edge onward. The bench therefore aligns to a slot boundary and counts whole carrier cycles before it reads `dac_o` one slot at a time. The bench tracks the slot index itself from reset release and samples every output on the falling edge after the edge that loaded it.

// File: rtl/iq_phase_loop.sv
module iq_phase_loop #(
  parameter int DW  = 14,
  parameter int GW  = 8,
  parameter int GSH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] adc_i,
  input  logic                 loop_en,
  input  logic signed [DW-1:0] sp_i,
  input  logic signed [DW-1:0] sp_q,
  input  logic        [GW-1:0] kp,
  input  logic        [GW-1:0] ki,
  output logic signed [DW-1:0] dac_o,
  output logic signed [DW-1:0] meas_i,
  output logic signed [DW-1:0] meas_q,
  output logic signed [DW-1:0] err_i,
  output logic signed [DW-1:0] err_q,
  output logic                 meas_valid
);
  localparam int WW = DW + GW + 3;
  localparam logic signed [WW-1:0] VMAX = (WW'(1) <<< (DW - 1)) - WW'(1);
  localparam logic signed [WW-1:0] VMIN = -VMAX - WW'(1);

  function automatic logic signed [DW-1:0] clip(input logic signed [WW-1:0] v);
    if (v > VMAX)      return VMAX[DW-1:0];
    else if (v < VMIN) return VMIN[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  logic [1:0] ph;
  logic signed [DW-1:0] s0, s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 2'd0;
      s0 <= '0;
      s1 <= '0;
      s2 <= '0;
    end else begin
      ph <= ph + 2'd1;
      case (ph)
        2'd0: s0 <= adc_i;
        2'd1: s1 <= adc_i;
        2'd2: s2 <= adc_i;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [DW-1:0] sp_c, meas_r, err_r, integ_r, cor_r, inext;
    logic signed [DW:0]   dif;
    logic signed [WW-1:0] e_w, p_w, i_w, c_w;

    assign sp_c  = (c == 0) ? sp_i : sp_q;
    assign dif   = (c == 0) ? ((DW+1)'(s0) - (DW+1)'(s2))
                            : ((DW+1)'(s1) - (DW+1)'(adc_i));
    assign e_w   = WW'(sp_c) - WW'(meas_r);
    assign p_w   = (WW'(err_r) * WW'($signed({1'b0, kp}))) >>> GSH;
    assign i_w   = WW'(integ_r) + ((WW'(err_r) * WW'($signed({1'b0, ki}))) >>> GSH);
    assign inext = clip(i_w);
    assign c_w   = WW'(sp_c) + p_w + WW'(inext);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meas_r  <= '0;
        err_r   <= '0;
        integ_r <= '0;
        cor_r   <= '0;
      end else begin
        if (ph == 2'd3) meas_r <= dif[DW:1];
        if (ph == 2'd0) err_r  <= clip(e_w);
        if (!loop_en) begin
          integ_r <= '0;
          cor_r   <= sp_c;
        end else if (ph == 2'd1) begin
          integ_r <= inext;
          cor_r   <= clip(c_w);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_o      <= '0;
      meas_valid <= 1'b0;
    end else begin
      meas_valid <= (ph == 2'd3);
      case (ph)
        2'd0:    dac_o <= g_ch[0].cor_r;
        2'd1:    dac_o <= g_ch[1].cor_r;
        2'd2:    dac_o <= clip(-WW'(g_ch[0].cor_r));
        default: dac_o <= clip(-WW'(g_ch[1].cor_r));
      endcase
    end
  end

  assign meas_i = g_ch[0].meas_r;
  assign meas_q = g_ch[1].meas_r;
  assign err_i  = g_ch[0].err_r;
  assign err_q  = g_ch[1].err_r;
endmodule

// File: rtl/iq_phase_loop_chk.sv
module iq_phase_loop_chk #(
  parameter int DW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           ph,
  input logic                 loop_en,
  input logic signed [DW-1:0] sp_i,
  input logic                 meas_valid,
  input logic signed [DW-1:0] meas_i,
  input logic signed [DW-1:0] meas_q,
  input logic signed [DW-1:0] dac_o,
  input logic signed [DW-1:0] cor_i,
  input logic signed [DW-1:0] integ_i,
  input logic signed [DW-1:0] integ_q
);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid);

  p_valid_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3) |=> meas_valid);

  p_meas_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |-> ($stable(meas_i) && $stable(meas_q)));

  p_open_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (cor_i == $past(sp_i)));

  p_integ_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (integ_i == '0 && integ_q == '0));

  p_dac_negate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3 && $past(loop_en) && cor_i != MINV) |-> (dac_o == -cor_i));
endmodule

bind iq_phase_loop iq_phase_loop_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph         (ph),
  .loop_en    (loop_en),
  .sp_i       (sp_i),
  .meas_valid (meas_valid),
  .meas_i     (meas_i),
  .meas_q     (meas_q),
  .dac_o      (dac_o),
  .cor_i      (g_ch[0].cor_r),
  .integ_i    (g_ch[0].integ_r),
  .integ_q    (g_ch[1].integ_r)
);

// File: tb/iq_phase_loop_bench.sv
module iq_phase_loop_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [13:0] adc_i = '0;
  logic loop_en = 1'b0;
  logic signed [13:0] sp_i = '0, sp_q = '0;
  logic [7:0] kp = '0, ki = '0;
  logic signed [13:0] dac_o, meas_i, meas_q, err_i, err_q;
  logic meas_valid;

  int checks = 0, failures = 0;
  int bph = 0;
  int wv [4] = '{0, 0, 0, 0};
  bit done = 1'b0;

  // sp_i, sp_q, amp_i, amp_q, exp meas_i, meas_q, err_i, err_q
  localparam int VEC [6][8] = '{
    '{    0,     0,  1000,  -500,  1000,  -500, -1000,   500},
    '{ 2000,  1500,  2000,  1500,  2000,  1500,     0,     0},
    '{-3000,  4000,   100,  -100,   100,  -100, -3100,  4100},
    '{ 8191, -8192, -8191,  8191, -8191,  8191,  8191, -8192},
    '{-8192,     0,  8191,     0,  8191,     0, -8192,     0},
    '{  500,  -500,    -1,     1,    -1,     1,   501,  -501}
  };

  iq_phase_loop u_iq_phase_loop (
    .clk(clk), .rst_n(rst_n), .adc_i(adc_i), .loop_en(loop_en),
    .sp_i(sp_i), .sp_q(sp_q), .kp(kp), .ki(ki), .dac_o(dac_o),
    .meas_i(meas_i), .meas_q(meas_q), .err_i(err_i), .err_q(err_q),
    .meas_valid(meas_valid));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    adc_i = 14'(wv[bph]);
    @(posedge clk);
    bph = (bph + 1) % 4;
    @(negedge clk);
  endtask

  task automatic align();
    while (bph != 0) tick();
  endtask

  task automatic set_wave(input int a0, input int a1, input int a2, input int a3);
    wv[0] = a0; wv[1] = a1; wv[2] = a2; wv[3] = a3;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dac", int'(dac_o), 0);
    chk("R1 meas_i", int'(meas_i), 0);
    chk("R1 err_q", int'(err_q), 0);
    chk("R1 valid", int'(meas_valid), 0);
    rst_n = 1'b1;
    bph = 0;

    // R2 R4 vector table, open loop
    for (int v = 0; v < 6; v++) begin
      align();
      sp_i = 14'(VEC[v][0]);
      sp_q = 14'(VEC[v][1]);
      set_wave(VEC[v][2], VEC[v][3], -VEC[v][2], -VEC[v][3]);
      repeat (8) tick();
      chk("R2 meas_i", int'(meas_i), VEC[v][4]);
      chk("R2 meas_q", int'(meas_q), VEC[v][5]);
      chk("R4 err_i", int'(err_i), VEC[v][6]);
      chk("R4 err_q", int'(err_q), VEC[v][7]);
      if (v == 0) begin
        chk("R3 valid high", int'(meas_valid), 1);
        tick();
        chk("R3 valid low", int'(meas_valid), 0);
        chk("R3 meas held", int'(meas_i), VEC[v][4]);
      end
    end

    // R2 floor averaging of asymmetric samples
    align();
    set_wave(101, 51, -100, -50);
    repeat (8) tick();
    chk("R2 floor i", int'(meas_i), 100);
    chk("R2 floor q", int'(meas_q), 50);
    set_wave(-101, 0, 100, 0);
    repeat (8) tick();
    chk("R2 floor neg", int'(meas_i), -101);

    // R5 R6 open-loop modulator sequence
    align();
    loop_en = 1'b0;
    sp_i = 14'sd3000;
    sp_q = -14'sd1200;
    repeat (8) tick();
    chk("R6 slot3 -Q", int'(dac_o), 1200);
    tick(); chk("R5 R6 slot0 I", int'(dac_o), 3000);
    tick(); chk("R6 slot1 Q", int'(dac_o), -1200);
    tick(); chk("R6 slot2 -I", int'(dac_o), -3000);

    // R6 negation saturation
    align();
    sp_i = -14'sd8192;
    repeat (8) tick();
    repeat (3) tick();
    chk("R6 neg sat", int'(dac_o), 8191);

    // R7 proportional path
    align();
    sp_i = 14'sd1000; sp_q = '0;
    kp = 8'd16; ki = 8'd0;
    set_wave(600, 200, -600, -200);
    repeat (8) tick();
    loop_en = 1'b1;
    repeat (4) tick();
    tick(); chk("R7 unity i", int'(dac_o), 1400);
    tick(); chk("R7 unity q", int'(dac_o), -200);
    align();
    kp = 8'd8;
    repeat (4) tick();
    tick(); chk("R7 half i", int'(dac_o), 1200);
    tick(); chk("R7 half q", int'(dac_o), -100);

    // R8 integral accumulation and saturation
    align();
    loop_en = 1'b0;
    kp = 8'd0; ki = 8'd16;
    set_wave(600, 0, -600, 0);
    repeat (8) tick();
    loop_en = 1'b1;
    repeat (12) tick();
    tick(); chk("R8 accumulate", int'(dac_o), 2200);
    align();
    repeat (120) tick();
    tick(); chk("R8 sat out", int'(dac_o), 8191);
    align();
    ki = 8'd0;
    sp_i = -14'sd8000;
    repeat (4) tick();
    tick(); chk("R8 integ held at 8191", int'(dac_o), 191);

    // R9 disable clears integrators
    align();
    loop_en = 1'b0;
    repeat (4) tick();
    loop_en = 1'b1;
    repeat (4) tick();
    tick(); chk("R9 integ cleared", int'(dac_o), -8000);

    done = 1'b1;
    finish_run();
  end
endmodule